// File: doc/BRIEF.md
# Environment configuration registers with fence widening

This block holds the machine-level and supervisor-level environment configuration registers of a RISC-V style core. A simple CSR port drives it. The port carries a request strobe, a write strobe, a 12-bit address, 64-bit write data, the current privilege level and the XLEN mode of the core. The block checks each access against the privilege and the implemented modes. It legalizes written values so that only the flag meaning "an I/O fence also orders memory" is kept. The block reports an illegal access on a registered output one cycle later.

From the current privilege and the two stored flags, the block derives whether the flag is in force. It then rewrites the predecessor and successor sets of a FENCE instruction into effective sets. The decoder supplies the raw sets. The memory-ordering logic consumes the widened ones.

Top module: `envcfg_ctrl`

## Requirements
- R1: After reset both registers hold zero: reads of 0x30A and 0x10A return 0, and the active flag is 0.
- R2: A legal write to 0x30A stores write-data bit 0 as the flag. Every other bit reads back as zero, even after writing all ones.
- R3: Address 0x10A holds the supervisor flag. Writes to it are legal from Machine (priv 3) or Supervisor (priv 1) mode. It reads back zero-extended, so only bit 0 can be non-zero.
- R4: In 32-bit mode (xlen64_i = 0), 0x30A reaches the low half of the machine register and 0x31A reaches the high half. A write to one half leaves the other half unchanged, and 0x31A always reads zero.
- R5: With FIOM_SUPPORT = 0, writes cannot set either flag, and both registers read as 0.
- R6: The active flag is 0 in Machine mode. In Supervisor mode it equals the machine flag. In User mode (priv 0) it is the OR of the machine and supervisor flags. For priv 2 it is 0.
- R7: Fence sets are coded as bit 3 = I, bit 2 = O, bit 1 = R, bit 0 = W. While the flag is active, the effective R is R|I and the effective W is W|O, with I and O passed through. The same rule applies to both the predecessor and successor sets. While the flag is inactive, the sets pass unchanged.
- R8: Some envcfg accesses are illegal: 0x30A or 0x31A outside Machine mode or without User mode, 0x31A in 64-bit mode, and 0x10A without Supervisor mode or from a privilege other than 1 or 3. Such an access raises csr_illegal_o for exactly the following cycle and leaves both registers unchanged. Other addresses never raise it and read 0.
- R9: A register write takes effect at the clock edge that accepts it. Fences evaluated in the following cycle see the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_req_i | input | 1 | CSR access request |
| csr_we_i | input | 1 | Write strobe (with request) |
| csr_addr_i | input | 12 | CSR address |
| csr_wdata_i | input | 64 | Write data |
| priv_i | input | 2 | Current privilege: 0 U, 1 S, 3 M |
| xlen64_i | input | 1 | 1 = 64-bit mode, 0 = 32-bit mode |
| csr_rdata_o | output | 64 | Read data for the addressed register |
| csr_illegal_o | output | 1 | One-cycle illegal-access pulse |
| fence_pred_i | input | 4 | Raw predecessor set (IORW) |
| fence_succ_i | input | 4 | Raw successor set (IORW) |
| fence_pred_o | output | 4 | Effective predecessor set |
| fence_succ_o | output | 4 | Effective successor set |
| fiom_active_o | output | 1 | Flag in force at the current privilege |

## Verification
The bench builds two copies that share the same stimulus. The first uses the defaults, with the flag supported and both lower modes present. That brings in the full privilege matrix, the split halves in 32-bit mode and the widening at every privilege. The second is built with FIOM_SUPPORT = 0 and no Supervisor mode. That makes the flag read as zero after a write of ones, and makes every access to 0x10A illegal.

// File: rtl/envcfg_pkg.sv
package envcfg_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 64;
    localparam int SET_W  = 4;

    localparam logic [ADDR_W-1:0] ADDR_MCFG   = 12'h30A;
    localparam logic [ADDR_W-1:0] ADDR_MCFG_H = 12'h31A;
    localparam logic [ADDR_W-1:0] ADDR_SCFG   = 12'h10A;

    // Bit positions inside a fence set
    localparam int BIT_I = 3;
    localparam int BIT_O = 2;
    localparam int BIT_R = 1;
    localparam int BIT_W = 0;

    typedef enum logic [1:0] {
        PRIV_U = 2'd0,
        PRIV_S = 2'd1,
        PRIV_H = 2'd2,
        PRIV_M = 2'd3
    } priv_e;

    typedef struct packed {
        logic m_flag;
        logic s_flag;
        logic illegal;
    } cfg_state_t;
endpackage

// File: rtl/envcfg_decode.sv
module envcfg_decode
    import envcfg_pkg::*;
#(
    parameter bit HAS_SMODE = 1'b1,
    parameter bit HAS_UMODE = 1'b1
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        priv_i,
    input  logic              xlen64_i,
    output logic              hit_o,
    output logic              legal_o,
    output logic              sel_m_lo_o,
    output logic              sel_m_hi_o,
    output logic              sel_s_o
);
    logic is_m_lo, is_m_hi, is_s;
    logic m_ok, s_ok;

    always_comb begin
        is_m_lo = (addr_i == ADDR_MCFG);
        is_m_hi = (addr_i == ADDR_MCFG_H);
        is_s    = (addr_i == ADDR_SCFG);
        m_ok    = HAS_UMODE && (priv_i == PRIV_M);
        s_ok    = HAS_SMODE && ((priv_i == PRIV_M) || (priv_i == PRIV_S));

        hit_o      = is_m_lo || is_m_hi || is_s;
        sel_m_lo_o = is_m_lo && m_ok;
        sel_m_hi_o = is_m_hi && m_ok && !xlen64_i;
        sel_s_o    = is_s && s_ok;
        legal_o    = sel_m_lo_o || sel_m_hi_o || sel_s_o;
    end
endmodule

// File: rtl/envcfg_fence_widen.sv
module envcfg_fence_widen
    import envcfg_pkg::*;
(
    input  logic             widen_i,
    input  logic [SET_W-1:0] set_i,
    output logic [SET_W-1:0] set_o
);
    always_comb begin
        set_o = set_i;
        if (widen_i) begin
            set_o[BIT_R] = set_i[BIT_R] | set_i[BIT_I];
            set_o[BIT_W] = set_i[BIT_W] | set_i[BIT_O];
        end
    end
endmodule

// File: rtl/envcfg_ctrl.sv
module envcfg_ctrl
    import envcfg_pkg::*;
#(
    parameter bit FIOM_SUPPORT = 1'b1,
    parameter bit HAS_SMODE    = 1'b1,
    parameter bit HAS_UMODE    = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              csr_req_i,
    input  logic              csr_we_i,
    input  logic [ADDR_W-1:0] csr_addr_i,
    input  logic [DATA_W-1:0] csr_wdata_i,
    input  logic [1:0]        priv_i,
    input  logic              xlen64_i,
    output logic [DATA_W-1:0] csr_rdata_o,
    output logic              csr_illegal_o,
    input  logic [SET_W-1:0]  fence_pred_i,
    input  logic [SET_W-1:0]  fence_succ_i,
    output logic [SET_W-1:0]  fence_pred_o,
    output logic [SET_W-1:0]  fence_succ_o,
    output logic              fiom_active_o
);
    localparam int NSETS = 2;

    cfg_state_t st_d, st_q;
    logic hit, legal, sel_m_lo, sel_m_hi, sel_s;
    logic wr_flag;
    logic [SET_W-1:0] raw_sets [NSETS];
    logic [SET_W-1:0] eff_sets [NSETS];

    envcfg_decode #(
        .HAS_SMODE (HAS_SMODE),
        .HAS_UMODE (HAS_UMODE)
    ) u_decode (
        .addr_i     (csr_addr_i),
        .priv_i     (priv_i),
        .xlen64_i   (xlen64_i),
        .hit_o      (hit),
        .legal_o    (legal),
        .sel_m_lo_o (sel_m_lo),
        .sel_m_hi_o (sel_m_hi),
        .sel_s_o    (sel_s)
    );

    // Next-state logic
    always_comb begin
        st_d         = st_q;
        wr_flag      = FIOM_SUPPORT ? csr_wdata_i[0] : 1'b0;
        st_d.illegal = csr_req_i && hit && !legal;
        if (csr_req_i && csr_we_i) begin
            if (sel_m_lo) st_d.m_flag = wr_flag;
            if (sel_s)    st_d.s_flag = wr_flag;
            // the high half carries no implemented field
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Read path and active flag
    always_comb begin
        csr_rdata_o = '0;
        if (sel_m_lo)    csr_rdata_o[0] = st_q.m_flag;
        else if (sel_s)  csr_rdata_o[0] = st_q.s_flag;
        csr_illegal_o = st_q.illegal;

        unique case (priv_i)
            PRIV_S:  fiom_active_o = st_q.m_flag;
            PRIV_U:  fiom_active_o = st_q.m_flag | st_q.s_flag;
            default: fiom_active_o = 1'b0;
        endcase
    end

    assign raw_sets[0] = fence_pred_i;
    assign raw_sets[1] = fence_succ_i;

    for (genvar g = 0; g < NSETS; g++) begin : g_widen
        envcfg_fence_widen u_widen (
            .widen_i (fiom_active_o),
            .set_i   (raw_sets[g]),
            .set_o   (eff_sets[g])
        );
    end

    assign fence_pred_o = eff_sets[0];
    assign fence_succ_o = eff_sets[1];

    // Assertions
    a_r6_machine_inactive: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i == PRIV_M) |-> !fiom_active_o);

    a_r7_io_passthrough: assert property (@(posedge clk) disable iff (!rst_n)
        (fence_pred_o[BIT_I:BIT_O] == fence_pred_i[BIT_I:BIT_O]) &&
        (fence_succ_o[BIT_I:BIT_O] == fence_succ_i[BIT_I:BIT_O]));

    a_r7_superset: assert property (@(posedge clk) disable iff (!rst_n)
        ((fence_pred_o & fence_pred_i) == fence_pred_i) &&
        ((fence_succ_o & fence_succ_i) == fence_succ_i));

    a_r8_illegal_holds: assert property (@(posedge clk) disable iff (!rst_n)
        csr_illegal_o |-> (st_q.m_flag == $past(st_q.m_flag)) &&
                          (st_q.s_flag == $past(st_q.s_flag)));

    a_r9_change_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.m_flag != $past(st_q.m_flag)) |->
            $past(csr_req_i && csr_we_i && csr_addr_i == ADDR_MCFG));
endmodule

// File: tb/tb_envcfg_ctrl.sv
`timescale 1ns/1ps
module tb_envcfg_ctrl;
    typedef enum int {K_RD, K_ILL, K_ACT, K_PRED, K_SUCC, K_BRD, K_BILL} kind_e;
    typedef struct {
        kind_e       kind;
        logic [63:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0;
    logic [11:0] addr = '0;
    logic [63:0] wdata = '0;
    logic [1:0]  priv = 2'd3;
    logic        x64 = 1'b1;
    logic [3:0]  pred = '0, succ = '0;
    logic [63:0] rdata, b_rdata;
    logic        ill, b_ill, act, b_act;
    logic [3:0]  pred_o, succ_o, b_pred_o, b_succ_o;

    int checks = 0, errors = 0;
    item_t q[$];
    event sample_ev;
    bit done = 1'b0;

    always #4 clk = ~clk;

    envcfg_ctrl dut (
        .clk(clk), .rst_n(rst_n), .csr_req_i(req), .csr_we_i(we),
        .csr_addr_i(addr), .csr_wdata_i(wdata), .priv_i(priv), .xlen64_i(x64),
        .csr_rdata_o(rdata), .csr_illegal_o(ill),
        .fence_pred_i(pred), .fence_succ_i(succ),
        .fence_pred_o(pred_o), .fence_succ_o(succ_o), .fiom_active_o(act));

    envcfg_ctrl #(.FIOM_SUPPORT(1'b0), .HAS_SMODE(1'b0), .HAS_UMODE(1'b1)) dut_b (
        .clk(clk), .rst_n(rst_n), .csr_req_i(req), .csr_we_i(we),
        .csr_addr_i(addr), .csr_wdata_i(wdata), .priv_i(priv), .xlen64_i(x64),
        .csr_rdata_o(b_rdata), .csr_illegal_o(b_ill),
        .fence_pred_i(pred), .fence_succ_i(succ),
        .fence_pred_o(b_pred_o), .fence_succ_o(b_succ_o), .fiom_active_o(b_act));

    // Monitor: pops expected items and compares
    initial begin
        forever begin
            @(sample_ev);
            while (q.size() > 0) begin
                item_t it;
                logic [63:0] got;
                it = q.pop_front();
                case (it.kind)
                    K_RD:    got = rdata;
                    K_ILL:   got = {63'b0, ill};
                    K_ACT:   got = {63'b0, act};
                    K_PRED:  got = {60'b0, pred_o};
                    K_SUCC:  got = {60'b0, succ_o};
                    K_BRD:   got = b_rdata;
                    default: got = {63'b0, b_ill};
                endcase
                checks++;
                if (got !== it.exp) begin
                    errors++;
                    $display("FAIL %s kind=%s actual=%h expected=%h",
                             it.req, it.kind.name(), got, it.exp);
                end
            end
        end
    end

    task automatic push(kind_e k, logic [63:0] e, string r);
        item_t it;
        it.kind = k; it.exp = e; it.req = r;
        q.push_back(it);
    endtask

    task automatic flush();
        -> sample_ev;
        #1;
    endtask

    // One CSR access; optional read check before the edge, illegal check after
    task automatic acc(input logic w, input logic [11:0] a, input logic [63:0] d,
                       input logic [1:0] p, input logic m64,
                       input bit chk_rd, input logic [63:0] e_rd, input logic e_ill,
                       input bit chk_b, input logic e_bill, input string r);
        @(negedge clk);
        req = 1'b1; we = w; addr = a; wdata = d; priv = p; x64 = m64;
        #1;
        if (chk_rd) push(K_RD, e_rd, r);
        if (chk_b)  push(K_BRD, 64'd0, {r, "/R5"});
        flush();
        @(posedge clk);
        @(negedge clk);
        req = 1'b0; we = 1'b0;
        push(K_ILL, {63'b0, e_ill}, r);
        if (chk_b) push(K_BILL, {63'b0, e_bill}, {r, "/R8"});
        flush();
    endtask

    task automatic fence(input logic [1:0] p, input logic [3:0] pi, input logic [3:0] si,
                         input logic [3:0] ep, input logic [3:0] es, input logic ea,
                         input string r);
        @(negedge clk);
        priv = p; pred = pi; succ = si;
        #1;
        push(K_ACT, {63'b0, ea}, r);
        push(K_PRED, {60'b0, ep}, r);
        push(K_SUCC, {60'b0, es}, r);
        flush();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1 reset state
        acc(0, 12'h30A, 0, 3, 1, 1, 64'd0, 0, 1, 0, "R1 m read");
        acc(0, 12'h10A, 0, 1, 1, 1, 64'd0, 0, 1, 1, "R1 s read");
        fence(0, 4'b1000, 4'b0100, 4'b1000, 4'b0100, 0, "R1 inactive");

        // R2 write all ones; R9 next-cycle effect
        acc(1, 12'h30A, '1, 3, 1, 0, 0, 0, 1, 0, "R2 write");
        fence(1, 4'b1000, 4'b0100, 4'b1010, 4'b0101, 1, "R9 R7 S widen");
        acc(0, 12'h30A, 0, 3, 1, 1, 64'd1, 0, 1, 0, "R2 readback");
        fence(3, 4'b1000, 4'b0100, 4'b1000, 4'b0100, 0, "R6 M inactive");
        fence(0, 4'b1100, 4'b1100, 4'b1111, 4'b1111, 1, "R7 U widen");
        fence(2, 4'b1100, 4'b0011, 4'b1100, 4'b0011, 0, "R6 priv2");

        // R3 supervisor register; R6 S vs U
        acc(1, 12'h30A, 0, 3, 1, 0, 0, 0, 1, 0, "R2 clear");
        acc(1, 12'h10A, 64'hFFFF_0000_0000_0001, 1, 1, 0, 0, 0, 1, 1, "R3 s write");
        acc(0, 12'h10A, 0, 1, 1, 1, 64'd1, 0, 1, 1, "R3 s read");
        acc(0, 12'h10A, 0, 3, 0, 1, 64'd1, 0, 1, 1, "R3 zero-extend x32");
        fence(1, 4'b1000, 4'b0100, 4'b1000, 4'b0100, 0, "R6 S ignores s flag");
        fence(0, 4'b0100, 4'b1000, 4'b0101, 4'b1010, 1, "R6 U or");

        // R4 32-bit halves
        acc(1, 12'h30A, 64'hFFFF_FFFF, 3, 0, 0, 0, 0, 1, 0, "R4 low write");
        acc(1, 12'h31A, 64'h0, 3, 0, 0, 0, 0, 1, 0, "R4 high write");
        acc(0, 12'h31A, 0, 3, 0, 1, 64'd0, 0, 1, 0, "R4 high read");
        acc(0, 12'h30A, 0, 3, 0, 1, 64'd1, 0, 1, 0, "R4 low kept");

        // R8 illegal accesses
        acc(1, 12'h30A, 0, 1, 1, 1, 64'd0, 1, 1, 1, "R8 m from S");
        acc(0, 12'h30A, 0, 3, 1, 1, 64'd1, 0, 1, 0, "R8 m unchanged");
        acc(1, 12'h31A, 0, 3, 1, 1, 64'd0, 1, 1, 1, "R8 high in x64");
        acc(1, 12'h10A, 0, 0, 1, 1, 64'd0, 1, 1, 1, "R8 s from U");
        acc(1, 12'h10A, 0, 2, 1, 1, 64'd0, 1, 1, 1, "R8 s from priv2");
        acc(0, 12'h10A, 0, 3, 1, 1, 64'd1, 0, 1, 1, "R8 s unchanged one-cycle");
        acc(1, 12'h300, '1, 0, 1, 1, 64'd0, 0, 1, 0, "R8 foreign addr");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule